// File: doc/BRIEF.md
# SPI Master Serial Clock Generator

This block produces the serial clock for an SPI master. It runs on the peripheral clock and has two stages. A power-of-two prescaler makes a base tick. Two phase counters then time the level of the serial clock in whole base ticks. The high level and the low level each take their own count, so the duty cycle can be asymmetric. When the block is idle, the clock rests at a programmable idle polarity. Each clock period starts with the non-idle phase and ends with the phase at the idle level.

The shift logic around it uses two single-cycle strobes. One marks each leading edge (idle level to non-idle level). The other marks each trailing edge (back to the idle level). The divider field and the two phase counts are sampled only when a phase begins, so changing them never distorts a phase already in progress.

Releasing the run request lets the current period run to its end; the block then stops at the idle level. Dropping the master-mode flag stops the clock at once.

Top module: `spi_sck_gen`

## Requirements
- R1: While reset is asserted, and until the first start after it, `sck_o` equals `idle_pol_i` and both strobes are 0.
- R2: The base tick occurs once every 2^`scale_i` peripheral clocks. A phase with count N lasts N × 2^scale peripheral clocks.
- R3: A `scale_i` value above 8 behaves exactly like 8, so the divisor is never larger than 256.
- R4: The high level lasts `hi_cnt_i` base ticks and the low level lasts `lo_cnt_i` base ticks. The two are independent. With idle polarity 0 the non-idle phase is high; with idle polarity 1 it is low.
- R5: A count value of 0 in `hi_cnt_i` or `lo_cnt_i` gives a phase of 256 base ticks.
- R6: From idle, when `master_en_i` and `run_i` are both seen high at a clock edge, `sck_o` changes to the non-idle level (the inverse of `idle_pol_i`) in the cycle after that edge.
- R7: `lead_stb_o` is high for exactly the one cycle in which `sck_o` first shows the non-idle level of a period. `trail_stb_o` is high for exactly the one cycle in which `sck_o` returns to the idle level at the end of a non-idle phase. The two strobes are never high together.
- R8: Scale, high count and low count are sampled at the clock edge that starts a phase. Values applied during a phase affect only later phases. A value applied in the last cycle of a phase is taken by the phase that follows.
- R9: If `run_i` is low at the end of an idle-level phase, the block returns to idle with no further leading edge. A period already started always completes both of its phases.
- R10: If `master_en_i` is seen low at a clock edge, then from the next cycle on `sck_o` equals `idle_pol_i` and no strobe is produced until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| master_en_i | input | 1 | Block operates as a bus master; low stops the clock |
| run_i | input | 1 | Request to produce clock periods |
| scale_i | input | 4 | Prescaler exponent; divisor is 2^scale, clamped at 8 |
| hi_cnt_i | input | 8 | High-level duration in base ticks, 0 means 256 |
| lo_cnt_i | input | 8 | Low-level duration in base ticks, 0 means 256 |
| idle_pol_i | input | 1 | Level of the serial clock when idle |
| sck_o | output | 1 | Serial clock |
| lead_stb_o | output | 1 | One-cycle strobe on each leading edge |
| trail_stb_o | output | 1 | One-cycle strobe on each trailing edge |

## Verification
Two functions can coincide with the end of a phase. One is the sampling of new divider and count settings. The other is the decision whether a released run request ends the clock. The bench changes the high count, and in a separate case drops `run_i`, exactly in the last cycle of an idle-level phase. It then judges whether the next phase takes the new length and whether a further leading edge appears. A mid-phase change of a count is also checked, to confirm that the phase already running keeps its original length.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

  typedef enum logic [1:0] {
    SCK_IDLE  = 2'd0,
    SCK_LEAD  = 2'd1,
    SCK_TRAIL = 2'd2
  } sck_state_e;

  function automatic int unsigned pre_width(input int unsigned max_scale);
    return (max_scale > 0) ? max_scale : 1;
  endfunction

endpackage

// File: rtl/sck_rst_sync.sv
module sck_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/sck_cfg_sel.sv
module sck_cfg_sel #(
  parameter int unsigned SCALE_W   = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_SCALE = 8
) (
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [CNT_W-1:0]   hi_cnt_i,
  input  logic [CNT_W-1:0]   lo_cnt_i,
  input  logic               want_high_i,
  output logic [SCALE_W-1:0] scale_eff_o,
  output logic [CNT_W:0]     phase_len_o
);

  localparam logic [SCALE_W-1:0] SCALE_CAP = SCALE_W'(MAX_SCALE);
  localparam logic [CNT_W:0]     LEN_FULL  = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W-1:0] cnt_pick;

  always_comb begin
    if (scale_i > SCALE_CAP) begin
      scale_eff_o = SCALE_CAP;
    end else begin
      scale_eff_o = scale_i;
    end
  end

  always_comb begin
    cnt_pick = want_high_i ? hi_cnt_i : lo_cnt_i;
    if (cnt_pick == '0) begin
      phase_len_o = LEN_FULL;
    end else begin
      phase_len_o = {1'b0, cnt_pick};
    end
  end

endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
  import spi_sck_pkg::*;
#(
  parameter int unsigned SCALE_W   = 4,
  parameter int unsigned MAX_SCALE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               en_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_o
);

  localparam int unsigned PRE_W = pre_width(MAX_SCALE);

  logic [SCALE_W-1:0] scale_q, scale_d;
  logic [PRE_W-1:0]   cnt_q, cnt_d;
  logic [PRE_W:0]     span;
  logic [PRE_W-1:0]   limit;

  always_comb begin
    span  = ((PRE_W+1)'(1) << scale_q) - (PRE_W+1)'(1);
    limit = span[PRE_W-1:0];
  end

  assign tick_o = en_i && (cnt_q == limit);

  always_comb begin
    scale_d = scale_q;
    cnt_d   = cnt_q;
    if (load_i) begin
      scale_d = scale_i;
      cnt_d   = '0;
    end else if (en_i) begin
      if (cnt_q == limit) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= '0;
      cnt_q   <= '0;
    end else begin
      scale_q <= scale_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sck_phase_timer.sv
module sck_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [CNT_W:0] len_i,
  input  logic           tick_i,
  output logic           done_o
);

  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W:0] rem_q, rem_d;

  assign done_o = tick_i && (rem_q == ONE);

  always_comb begin
    rem_d = rem_q;
    if (load_i) begin
      rem_d = len_i;
    end else if (tick_i && (rem_q > ONE)) begin
      rem_d = rem_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= ONE;
    end else begin
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_sck_pkg::*;
#(
  parameter int unsigned SCALE_W   = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MAX_SCALE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               master_en_i,
  input  logic               run_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [CNT_W-1:0]   hi_cnt_i,
  input  logic [CNT_W-1:0]   lo_cnt_i,
  input  logic               idle_pol_i,
  output logic               sck_o,
  output logic               lead_stb_o,
  output logic               trail_stb_o
);

  logic rst_n_int;

  sck_state_e state_q, state_d;
  logic       pol_q, pol_d;
  logic       lead_q, lead_d;
  logic       trail_q, trail_d;
  logic       start;
  logic       want_high;
  logic       tick;
  logic       phase_done;
  logic       active;

  logic [SCALE_W-1:0] scale_eff;
  logic [CNT_W:0]     phase_len;

  sck_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  // Level of the phase that is about to begin decides which count applies.
  always_comb begin
    if (state_d == SCK_LEAD) begin
      want_high = ~idle_pol_i;
    end else begin
      want_high = pol_q;
    end
  end

  sck_cfg_sel #(
    .SCALE_W   (SCALE_W),
    .CNT_W     (CNT_W),
    .MAX_SCALE (MAX_SCALE)
  ) u_cfg (
    .scale_i     (scale_i),
    .hi_cnt_i    (hi_cnt_i),
    .lo_cnt_i    (lo_cnt_i),
    .want_high_i (want_high),
    .scale_eff_o (scale_eff),
    .phase_len_o (phase_len)
  );

  assign active = (state_q != SCK_IDLE);

  sck_prescaler #(
    .SCALE_W   (SCALE_W),
    .MAX_SCALE (MAX_SCALE)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_i  (start),
    .en_i    (active),
    .scale_i (scale_eff),
    .tick_o  (tick)
  );

  sck_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load_i (start),
    .len_i  (phase_len),
    .tick_i (tick),
    .done_o (phase_done)
  );

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    unique case (state_q)
      SCK_IDLE: begin
        if (master_en_i && run_i) begin
          state_d = SCK_LEAD;
          start   = 1'b1;
        end
      end
      SCK_LEAD: begin
        if (!master_en_i) begin
          state_d = SCK_IDLE;
        end else if (phase_done) begin
          state_d = SCK_TRAIL;
          start   = 1'b1;
        end
      end
      SCK_TRAIL: begin
        if (!master_en_i) begin
          state_d = SCK_IDLE;
        end else if (phase_done) begin
          if (run_i) begin
            state_d = SCK_LEAD;
            start   = 1'b1;
          end else begin
            state_d = SCK_IDLE;
          end
        end
      end
      default: begin
        state_d = SCK_IDLE;
      end
    endcase
  end

  always_comb begin
    pol_d   = pol_q;
    lead_d  = 1'b0;
    trail_d = 1'b0;
    if (start && (state_d == SCK_LEAD)) begin
      pol_d  = idle_pol_i;
      lead_d = 1'b1;
    end
    if (start && (state_d == SCK_TRAIL)) begin
      trail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= SCK_IDLE;
      pol_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pol_q   <= pol_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  always_comb begin
    unique case (state_q)
      SCK_LEAD:  sck_o = ~pol_q;
      SCK_TRAIL: sck_o = pol_q;
      default:   sck_o = idle_pol_i;
    endcase
  end

  assign lead_stb_o  = lead_q;
  assign trail_stb_o = trail_q;

endmodule

// File: rtl/sck_gen_checker.sv
module sck_gen_checker (
  input logic clk,
  input logic rst_n,
  input logic master_en_i,
  input logic idle_pol_i,
  input logic sck_o,
  input logic lead_stb_o,
  input logic trail_stb_o
);

  // R7: strobes are mutually exclusive
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb_o && trail_stb_o));

  // R7: a leading strobe never lasts two cycles
  assert_lead_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb_o |=> !lead_stb_o);

  // R7: each strobe coincides with a change of the serial clock level
  assert_lead_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb_o && $stable(idle_pol_i)) |-> (sck_o != $past(sck_o)));

  assert_trail_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_stb_o && $stable(idle_pol_i)) |-> (sck_o != $past(sck_o)));

  // R7: while in master mode, the clock only moves together with a strobe
  assert_move_has_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(master_en_i) && $stable(idle_pol_i) && (sck_o != $past(sck_o)))
      |-> (lead_stb_o || trail_stb_o));

  // R10: leaving master mode parks the clock at the idle level with no strobe
  assert_no_master_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en_i |=> (!lead_stb_o && !trail_stb_o && (sck_o == idle_pol_i)));

endmodule

bind spi_sck_gen sck_gen_checker u_sck_gen_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .master_en_i (master_en_i),
  .idle_pol_i  (idle_pol_i),
  .sck_o       (sck_o),
  .lead_stb_o  (lead_stb_o),
  .trail_stb_o (trail_stb_o)
);

// File: tb/tb_spi_sck_gen.sv
module tb_spi_sck_gen;

  typedef struct packed {
    logic [3:0]  sc;
    logic [7:0]  hi;
    logic [7:0]  lo;
    logic        pol;
    logic [19:0] len_act;
    logic [19:0] len_idle;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  8'd1, 8'd1, 1'b0, 20'd1,   20'd1},
    '{4'd0,  8'd5, 8'd2, 1'b0, 20'd5,   20'd2},
    '{4'd0,  8'd5, 8'd2, 1'b1, 20'd2,   20'd5},
    '{4'd2,  8'd3, 8'd5, 1'b0, 20'd12,  20'd20},
    '{4'd1,  8'd4, 8'd1, 1'b1, 20'd2,   20'd8},
    '{4'd3,  8'd2, 8'd7, 1'b0, 20'd16,  20'd56},
    '{4'd0,  8'd0, 8'd3, 1'b0, 20'd256, 20'd3},
    '{4'd12, 8'd1, 8'd1, 1'b1, 20'd256, 20'd256},
    '{4'd8,  8'd1, 8'd2, 1'b0, 20'd256, 20'd512}
  };

  logic       clk;
  logic       rst_n;
  logic       master_en;
  logic       run;
  logic [3:0] scale;
  logic [7:0] hi_cnt;
  logic [7:0] lo_cnt;
  logic       idle_pol;
  logic       sck;
  logic       lead_stb;
  logic       trail_stb;

  int n_vec;
  int n_bad;
  int cyc;
  int both_hi;

  spi_sck_gen dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en_i (master_en),
    .run_i       (run),
    .scale_i     (scale),
    .hi_cnt_i    (hi_cnt),
    .lo_cnt_i    (lo_cnt),
    .idle_pol_i  (idle_pol),
    .sck_o       (sck),
    .lead_stb_o  (lead_stb),
    .trail_stb_o (trail_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (lead_stb && trail_stb) both_hi++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_lead(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!lead_stb && n < 70000);
  endtask

  task automatic wait_trail(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trail_stb && n < 70000);
  endtask

  task automatic quiet(input int cycles, input string req);
    int seen = 0;
    int lvl_bad = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (lead_stb || trail_stb) seen++;
      if (sck != idle_pol) lvl_bad++;
    end
    chk(seen == 0, req, seen, 0);
    chk(lvl_bad == 0, req, lvl_bad, 0);
  endtask

  initial begin
    int n;
    n_vec = 0; n_bad = 0; cyc = 0; both_hi = 0;
    rst_n = 1'b0; master_en = 1'b0; run = 1'b0;
    scale = '0; hi_cnt = 8'd1; lo_cnt = 8'd1; idle_pol = 1'b0;

    // R1: reset state for both idle polarities
    repeat (2) @(negedge clk);
    chk(sck == 1'b0 && !lead_stb && !trail_stb, "R1", int'(sck), 0);
    idle_pol = 1'b1;
    @(negedge clk);
    chk(sck == 1'b1 && !lead_stb && !trail_stb, "R1", int'(sck), 1);
    idle_pol = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sck == 1'b0 && !lead_stb && !trail_stb, "R1", int'(sck), 0);
    master_en = 1'b1;

    // Vector table: R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      scale = VEC[i].sc; hi_cnt = VEC[i].hi; lo_cnt = VEC[i].lo;
      idle_pol = VEC[i].pol;
      @(negedge clk);
      run = 1'b1;
      wait_lead(n);
      chk(n == 1, "R6", n, 1);
      chk(sck == ~VEC[i].pol, "R6", int'(sck), int'(~VEC[i].pol));
      wait_trail(n);
      chk(n == int'(VEC[i].len_act), "R2/R4", n, int'(VEC[i].len_act));
      chk(sck == VEC[i].pol, "R7", int'(sck), int'(VEC[i].pol));
      wait_lead(n);
      chk(n == int'(VEC[i].len_idle), "R2/R4", n, int'(VEC[i].len_idle));
      run = 1'b0;
      wait_trail(n);
      chk(n == int'(VEC[i].len_act), "R9", n, int'(VEC[i].len_act));
      quiet(int'(VEC[i].len_idle) + 4, "R9");
    end

    // R8: mid-phase change leaves the running phase untouched
    scale = 4'd0; hi_cnt = 8'd10; lo_cnt = 8'd4; idle_pol = 1'b0;
    @(negedge clk);
    run = 1'b1;
    wait_lead(n);
    repeat (3) @(negedge clk);
    hi_cnt = 8'd2;
    wait_trail(n);
    chk(n == 7, "R8", n, 7);
    wait_lead(n);
    chk(n == 4, "R8", n, 4);
    wait_trail(n);
    chk(n == 2, "R8", n, 2);

    // R8: change in the last cycle of an idle-level phase is taken next
    repeat (3) @(negedge clk);
    hi_cnt = 8'd6;
    wait_lead(n);
    chk(n == 1, "R8", n, 1);
    wait_trail(n);
    chk(n == 6, "R8", n, 6);

    // R9: run released in the last cycle of an idle-level phase
    repeat (3) @(negedge clk);
    run = 1'b0;
    quiet(20, "R9");

    // R10: leaving master mode mid-phase
    hi_cnt = 8'd8; lo_cnt = 8'd8;
    run = 1'b1;
    wait_lead(n);
    repeat (2) @(negedge clk);
    master_en = 1'b0;
    quiet(12, "R10");
    master_en = 1'b1;
    wait_lead(n);
    chk(n == 1, "R10", n, 1);
    run = 1'b0;
    wait_trail(n);
    quiet(12, "R9");

    // R7: strobes never overlapped during the whole run
    chk(both_hi == 0, "R7", both_hi, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule